// File: doc/BRIEF.md
# Link Frame Assembler with CRC-32

This block packs the readings of one acquisition card into a fixed 256-bit frame for a serial optical link. On an internal frame tick it samples eight 8-bit counter values with their status bits, eight 12-bit converter values, a 10-bit card status word and a 10-bit card number. It adds a sync pattern and a 16-bit frame serial number, and zero padding brings the data part to 224 bits. The frame then leaves as a burst of `WORD_W`-bit words (16 or 32), most significant bits first.

A CRC-32 (polynomial 0x04C11DB7) is accumulated over the data part while its words are being sent, in 16-bit steps, one or two per clock. The 32-bit remainder forms the last 32 bits of the frame. Each output word comes with a valid strobe, and the first word of a frame also carries a frame-start flag. The tick repeats every `FRAME_CYCLES` clocks, which is 1600 at a 40 MHz clock for a 40 µs frame rate.

Top module: `fa_frame_assembler`

## Requirements
- R1: While reset is asserted, `word_o` is 0 and `word_valid_o` and `frame_start_o` are low.
- R2: Consecutive frame-start flags are exactly `FRAME_CYCLES` clock cycles apart.
- R3: Each frame is sent as exactly 256/`WORD_W` words on consecutive cycles with `word_valid_o` high. `frame_start_o` is high only with the first of them, and `word_valid_o` is low between frames.
- R4: The frame fields go out most significant first, in this order: start pattern (16 bits), card number (10), frame ID (16), counter data (72), ADC data (96), card status (10), padding (4), CRC (32). Word 0 carries frame bits 255 down to 256-`WORD_W`.
- R5: The counter field holds channel 1 first and channel 8 last. Each entry is 9 bits, {status bit, 8-bit count}. Channel n takes its count from `cnt_value_i[8n-1 -: 8]` and its status bit from `cnt_status_i[n-1]`.
- R6: The ADC field holds channel 1 first and channel 8 last, 12 bits each. Channel n takes its value from `adc_value_i[12n-1 -: 12]`.
- R7: The 4 padding bits are always 0.
- R8: The last 32 bits hold a CRC over the 224 data bits. The CRC uses polynomial 0x04C11DB7, register preset to 0xFFFFFFFF, bits fed most significant first, no reflection and no final inversion.
- R9: The first frame after reset has frame ID 0. Each later frame carries the previous ID plus one, modulo 2^16.
- R10: Inputs are sampled only on the frame tick. Input changes during a frame do not affect that frame's content.
- R11: The start field equals the parameter `START_PATTERN`, which defaults to 16'hBC5A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_value_i | input | 64 | Eight 8-bit counter values, channel 1 in bits 7:0 |
| cnt_status_i | input | 8 | Per-channel counter status, channel 1 in bit 0 |
| adc_value_i | input | 96 | Eight 12-bit ADC values, channel 1 in bits 11:0 |
| card_status_i | input | 10 | Card status word |
| card_id_i | input | 10 | Card number |
| word_o | output | WORD_W | Current frame word |
| word_valid_o | output | 1 | `word_o` holds a frame word |
| frame_start_o | output | 1 | Current word is the first of a frame |

## Verification
The frame builder is driven with all-zero inputs, all-one inputs, a pattern with a distinct value in every channel, and a pseudo-random pattern. Each captured frame is compared field by field against a model built in the bench.
- The distinct-per-channel pattern shows up any swapped or reversed channel order, which uniform inputs would hide.
- The all-zero and all-one frames separate the CRC preset from the data contribution.
- A frame whose inputs change in the middle of the burst shows whether the inputs are sampled only once per frame.
- The spacing between frame starts and the run of valid words are measured in every frame.

// File: rtl/fa_pkg.sv
package fa_pkg;

    localparam int FRAME_BITS = 256;
    localparam int DATA_BITS  = 224;
    localparam int CRC_BITS   = 32;
    localparam int NUM_CH     = 8;
    localparam int CNT_W      = 8;
    localparam int ADC_W      = 12;
    localparam int CARD_W     = 10;
    localparam int STAT_W     = 10;
    localparam int FID_W      = 16;
    localparam int SYNC_W     = 16;
    localparam int STEP_W     = 16;
    localparam int CNT_FLD_W  = NUM_CH * (CNT_W + 1);
    localparam int ADC_FLD_W  = NUM_CH * ADC_W;
    localparam int PAD_W      = DATA_BITS - (SYNC_W + CARD_W + FID_W + CNT_FLD_W + ADC_FLD_W + STAT_W);

    localparam logic [CRC_BITS-1:0] CRC_POLY   = 32'h04C11DB7;
    localparam logic [CRC_BITS-1:0] CRC_PRESET = 32'hFFFFFFFF;

    // Data part of a frame, most significant field first
    typedef struct packed {
        logic [SYNC_W-1:0]    sync;
        logic [CARD_W-1:0]    card;
        logic [FID_W-1:0]     fid;
        logic [CNT_FLD_W-1:0] counters;
        logic [ADC_FLD_W-1:0] adcs;
        logic [STAT_W-1:0]    status;
        logic [PAD_W-1:0]     pad;
    } fa_data_t;

    // One 16-bit CRC step, data fed MSB first
    function automatic logic [CRC_BITS-1:0] crc_step(
        input logic [CRC_BITS-1:0] crc_in,
        input logic [STEP_W-1:0]   data
    );
        logic [CRC_BITS-1:0] c;
        logic                fb;
        c = crc_in;
        for (int b = STEP_W - 1; b >= 0; b--) begin
            fb = c[CRC_BITS-1] ^ data[b];
            c  = {c[CRC_BITS-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/fa_tick_gen.sv
module fa_tick_gen #(
    parameter int FRAME_CYCLES = 1600
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (FRAME_CYCLES > 1) ? $clog2(FRAME_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(FRAME_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (cnt_q == LAST) cnt_d = '0;
        else               cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = (cnt_q == '0);

    // R2
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/fa_field_pack.sv
module fa_field_pack
    import fa_pkg::*;
#(
    parameter logic [SYNC_W-1:0] START_PATTERN = 16'hBC5A
) (
    input  logic [NUM_CH*CNT_W-1:0] cnt_value_i,
    input  logic [NUM_CH-1:0]       cnt_status_i,
    input  logic [NUM_CH*ADC_W-1:0] adc_value_i,
    input  logic [STAT_W-1:0]       card_status_i,
    input  logic [CARD_W-1:0]       card_id_i,
    input  logic [FID_W-1:0]        fid_i,
    output fa_data_t                data_o
);
    localparam int ENT_W = CNT_W + 1;

    logic [CNT_FLD_W-1:0] cnt_field;
    logic [ADC_FLD_W-1:0] adc_field;

    // Channel 1 occupies the most significant entry of each field
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign cnt_field[CNT_FLD_W-1-g*ENT_W -: ENT_W] =
            {cnt_status_i[g], cnt_value_i[g*CNT_W +: CNT_W]};
        assign adc_field[ADC_FLD_W-1-g*ADC_W -: ADC_W] =
            adc_value_i[g*ADC_W +: ADC_W];
    end

    always_comb begin
        data_o          = '0;
        data_o.sync     = START_PATTERN;
        data_o.card     = card_id_i;
        data_o.fid      = fid_i;
        data_o.counters = cnt_field;
        data_o.adcs     = adc_field;
        data_o.status   = card_status_i;
        data_o.pad      = '0;
    end

endmodule

// File: rtl/fa_crc_word.sv
module fa_crc_word
    import fa_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic [CRC_BITS-1:0] crc_i,
    input  logic [WORD_W-1:0]   data_i,
    output logic [CRC_BITS-1:0] crc_o
);
    localparam int STEPS = WORD_W / STEP_W;

    logic [CRC_BITS-1:0] chain [STEPS+1];

    assign chain[0] = crc_i;

    for (genvar s = 0; s < STEPS; s++) begin : g_step
        assign chain[s+1] = crc_step(chain[s], data_i[WORD_W-1-s*STEP_W -: STEP_W]);
    end

    assign crc_o = chain[STEPS];

endmodule

// File: rtl/fa_frame_assembler.sv
module fa_frame_assembler
    import fa_pkg::*;
#(
    parameter int                WORD_W        = 16,
    parameter int                FRAME_CYCLES  = 1600,
    parameter logic [SYNC_W-1:0] START_PATTERN = 16'hBC5A
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH*CNT_W-1:0] cnt_value_i,
    input  logic [NUM_CH-1:0]       cnt_status_i,
    input  logic [NUM_CH*ADC_W-1:0] adc_value_i,
    input  logic [STAT_W-1:0]       card_status_i,
    input  logic [CARD_W-1:0]       card_id_i,
    output logic [WORD_W-1:0]       word_o,
    output logic                    word_valid_o,
    output logic                    frame_start_o
);
    localparam int NWORDS     = FRAME_BITS / WORD_W;
    localparam int DATA_WORDS = DATA_BITS / WORD_W;
    localparam int IDX_W      = $clog2(NWORDS + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);
    localparam logic [IDX_W-1:0] DATA_END = IDX_W'(DATA_WORDS);

    typedef struct packed {
        logic                active;
        logic [IDX_W-1:0]    idx;
        fa_data_t            data;
        logic [FID_W-1:0]    fid;
        logic [CRC_BITS-1:0] crc;
        logic [WORD_W-1:0]   word;
        logic                valid;
        logic                sof;
    } state_t;

    state_t st_d, st_q;

    logic                  tick;
    fa_data_t              packed_data;
    logic [FRAME_BITS-1:0] full_frame;
    logic [WORD_W-1:0]     cur_word;
    logic [CRC_BITS-1:0]   crc_next;

    fa_tick_gen #(
        .FRAME_CYCLES(FRAME_CYCLES)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_o(tick)
    );

    fa_field_pack #(
        .START_PATTERN(START_PATTERN)
    ) u_pack (
        .cnt_value_i  (cnt_value_i),
        .cnt_status_i (cnt_status_i),
        .adc_value_i  (adc_value_i),
        .card_status_i(card_status_i),
        .card_id_i    (card_id_i),
        .fid_i        (st_q.fid),
        .data_o       (packed_data)
    );

    assign full_frame = {st_q.data, st_q.crc};
    assign cur_word   = full_frame[FRAME_BITS-1-int'(st_q.idx)*WORD_W -: WORD_W];

    fa_crc_word #(
        .WORD_W(WORD_W)
    ) u_crc (
        .crc_i (st_q.crc),
        .data_i(cur_word),
        .crc_o (crc_next)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.sof   = 1'b0;
        if (st_q.active) begin
            st_d.word  = cur_word;
            st_d.valid = 1'b1;
            st_d.sof   = (st_q.idx == '0);
            if (st_q.idx < DATA_END) st_d.crc = crc_next;
            if (st_q.idx == LAST_IDX) st_d.active = 1'b0;
            else                      st_d.idx    = st_q.idx + 1'b1;
        end
        if (tick) begin
            st_d.active = 1'b1;
            st_d.idx    = '0;
            st_d.data   = packed_data;
            st_d.fid    = st_q.fid + 1'b1;
            st_d.crc    = CRC_PRESET;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o        = st_q.word;
    assign word_valid_o  = st_q.valid;
    assign frame_start_o = st_q.sof;

    // R2
    tick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> !st_q.active);

    // R3
    sof_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |-> word_valid_o);

    // R3
    burst_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_valid_o) |-> frame_start_o);

    // R8
    crc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && st_q.idx >= DATA_END) |=> $stable(st_q.crc));

    // R10
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !tick) |=> $stable(st_q.data));

endmodule

// File: tb/tb_fa_frame_assembler.sv
module tb_fa_frame_assembler;
    localparam int CLK_PERIOD   = 10;
    localparam int WORD_W       = 16;
    localparam int FRAME_CYCLES = 40;
    localparam int NWORDS       = 256 / WORD_W;
    localparam logic [15:0] SYNC = 16'hBC5A;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [63:0]  cnt_value = '0;
    logic [7:0]   cnt_status = '0;
    logic [95:0]  adc_value = '0;
    logic [9:0]   card_status = '0;
    logic [9:0]   card_id = '0;
    logic [WORD_W-1:0] word;
    logic         valid, sof;

    always #(CLK_PERIOD/2) clk = ~clk;

    fa_frame_assembler #(
        .WORD_W(WORD_W),
        .FRAME_CYCLES(FRAME_CYCLES)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .cnt_value_i(cnt_value), .cnt_status_i(cnt_status),
        .adc_value_i(adc_value), .card_status_i(card_status),
        .card_id_i(card_id),
        .word_o(word), .word_valid_o(valid), .frame_start_o(sof)
    );

    // Monitor: collects frames and checks timing (R2, R3)
    int           mon_checks = 0, mon_fails = 0;
    int           frames_done = 0, widx = 0, cyc = 0, last_sof = -1;
    logic         in_frame = 1'b0;
    logic [255:0] cap = '0, last_frame = '0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (sof) begin
                if (last_sof >= 0) begin
                    mon_checks++;
                    if (cyc - last_sof != FRAME_CYCLES) begin
                        mon_fails++;
                        $display("FAIL R2 frame spacing: got %0d expected %0d", cyc - last_sof, FRAME_CYCLES);
                    end
                end
                last_sof = cyc;
                widx     = 0;
                in_frame = 1'b1;
                if (!valid) begin
                    mon_fails++;
                    $display("FAIL R3 start flag without valid: got 0 expected 1");
                end
            end else if (valid && !in_frame) begin
                mon_fails++;
                $display("FAIL R3 valid outside frame: got 1 expected 0");
            end else if (in_frame && !valid) begin
                mon_fails++;
                $display("FAIL R3 gap in burst at word %0d: got 0 expected 1", widx);
                in_frame = 1'b0;
            end
            if (in_frame && valid) begin
                cap[255 - widx*WORD_W -: WORD_W] = word;
                widx = widx + 1;
                if (widx == NWORDS) begin
                    mon_checks++;
                    last_frame  = cap;
                    frames_done = frames_done + 1;
                    in_frame    = 1'b0;
                end
            end
        end
    end

    int checks = 0, fails = 0;

    task automatic check(input string req, input string what, input logic [127:0] got, input logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic logic [255:0] model(input logic [9:0] card, input logic [15:0] fid,
                                           input logic [63:0] cv, input logic [7:0] cs,
                                           input logic [95:0] av, input logic [9:0] st);
        logic [223:0] d;
        logic [31:0]  c;
        logic         fb;
        d = '0;
        d[223:208] = SYNC;
        d[207:198] = card;
        d[197:182] = fid;
        for (int n = 0; n < 8; n++) begin
            d[181 - n*9 -: 9]  = {cs[n], cv[n*8 +: 8]};
            d[109 - n*12 -: 12] = av[n*12 +: 12];
        end
        d[13:4] = st;
        c = 32'hFFFFFFFF;
        for (int i = 223; i >= 0; i--) begin
            fb = c[31] ^ d[i];
            c  = c << 1;
            if (fb) c = c ^ 32'h04C11DB7;
        end
        return {d, c};
    endfunction

    task automatic compare_frame(input string tag, input logic [255:0] exp);
        check("R11", {tag, " start"},   128'(last_frame[255:240]), 128'(exp[255:240]));
        check("R4",  {tag, " card"},    128'(last_frame[239:230]), 128'(exp[239:230]));
        check("R9",  {tag, " frame id"},128'(last_frame[229:214]), 128'(exp[229:214]));
        check("R5",  {tag, " counters"},128'(last_frame[213:142]), 128'(exp[213:142]));
        check("R6",  {tag, " adc"},     128'(last_frame[141:46]),  128'(exp[141:46]));
        check("R4",  {tag, " status"},  128'(last_frame[45:36]),   128'(exp[45:36]));
        check("R7",  {tag, " pad"},     128'(last_frame[35:32]),   128'(0));
        check("R8",  {tag, " crc"},     128'(last_frame[31:0]),    128'(exp[31:0]));
    endtask

    task automatic next_frame(input string tag);
        int target;
        target = frames_done + 1;
        wait (frames_done == target);
        compare_frame(tag, model(card_id, 16'(target - 1), cnt_value, cnt_status, adc_value, card_status));
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check("R1", "word in reset",  128'(word),  128'(0));
        check("R1", "valid in reset", 128'(valid), 128'(0));
        check("R1", "start in reset", 128'(sof),   128'(0));
        rst_n = 1'b1;
    endtask

    task automatic t_zeros;
        next_frame("zeros");
    endtask

    task automatic t_ones;
        cnt_value = '1; cnt_status = '1; adc_value = '1; card_status = '1; card_id = '1;
        next_frame("ones");
    endtask

    task automatic t_distinct;
        for (int n = 0; n < 8; n++) begin
            cnt_value[n*8 +: 8]  = 8'(8'h10 + n + 1);
            adc_value[n*12 +: 12] = 12'(12'h100 * (n + 1) + n + 1);
        end
        cnt_status  = 8'b0000_0101;
        card_status = 10'h2A5;
        card_id     = 10'h133;
        next_frame("distinct");
    endtask

    task automatic t_pseudo;
        logic [31:0] s;
        s = 32'hACE1_2357;
        for (int k = 0; k < 2; k++) begin
            for (int n = 0; n < 8; n++) begin
                s = s * 32'd1664525 + 32'd1013904223;
                cnt_value[n*8 +: 8]   = s[31:24];
                adc_value[n*12 +: 12] = s[19:8];
                cnt_status[n]         = s[5];
            end
            card_status = s[9:0];
            card_id     = s[29:20];
            next_frame("pseudo");
        end
    endtask

    // R10: inputs altered while the burst is under way
    task automatic t_midframe;
        logic [255:0] exp;
        int target;
        cnt_value = 64'h0123_4567_89AB_CDEF; cnt_status = 8'h3C;
        adc_value = 96'hFED_CBA_987_654_321_0FE_DCB_A98; card_status = 10'h0F0; card_id = 10'h055;
        target = frames_done + 1;
        exp = model(card_id, 16'(target - 1), cnt_value, cnt_status, adc_value, card_status);
        wait (in_frame == 1'b1);
        repeat (3) @(negedge clk);
        cnt_value = ~cnt_value; cnt_status = ~cnt_status; adc_value = ~adc_value;
        card_status = ~card_status; card_id = ~card_id;
        wait (frames_done == target);
        compare_frame("R10 midframe", exp);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + mon_checks, fails + mon_fails);
        $finish;
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_zeros();
                t_ones();
                t_distinct();
                t_midframe();
                t_pseudo();
                repeat (FRAME_CYCLES) @(negedge clk);
            end
            begin
                repeat (20000) @(posedge clk);
                fails++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        summary();
    end

endmodule